// File: doc/BRIEF.md
# Serial GF(2) Polynomial Divider

This block divides a dividend polynomial A(x) of degree DEG_A by a monic divisor B(x) of degree DEG_B, with all arithmetic over GF(2). It is built as a Galois-form shift register with DEG_B one-bit stages. The dividend enters one coefficient per accepted clock, highest power first, on `in_valid`/`in_bit`. The low DEG_B divisor coefficients are presented as a static word `b_coef`, where bit j gates the feedback XOR into stage j. The leading coefficient is always taken to be 1.

The top stage supplies the quotient estimate, and that estimate is broadcast to every tapped stage. Once the first DEG_B coefficients have filled the chain, one quotient bit leaves the block for each further accepted coefficient, highest power first. After the constant term a_0 has been absorbed, `done` pulses and the stages hold the remainder, which `rem` shows in parallel. Asserting `shift_out` while the remainder is held cuts the feedback. The stages then act as a plain shift register and present the remainder serially on `rem_bit`, highest power first.

A controller with four named states sequences the work:
- IDLE: cleared, waiting for the first coefficient.
- FILL: fewer than DEG_B coefficients absorbed, so the chain only shifts.
- DIVIDE: quotient bits are produced.
- HOLD: the remainder is held and may be shifted out.

The transitions are:
- CLEAR: `clr` takes any state to IDLE.
- START: the first accepted coefficient moves IDLE to FILL. When DEG_B is 1 it moves IDLE straight to DIVIDE.
- FILLED: the DEG_B-th accepted coefficient moves FILL to DIVIDE.
- FINISH: acceptance of a_0 moves the block to HOLD.
- Otherwise each state stays put.

Top module: `gf2div_serial`

## Requirements
- R1: A high `clr` on a clock edge zeroes every stage, so `rem` reads 0, and drives `q_valid` and `done` low from the next cycle.
- R2: For the first DEG_B accepted coefficients after a clear, `q_valid` stays low.
- R3: `q_valid` is high for exactly DEG_A−DEG_B+1 cycles per division. Each such cycle follows an accepted coefficient from the (DEG_B+1)-th onward. `q_bit` carries the quotient coefficients from q_(DEG_A−DEG_B) down to q_0 in that order.
- R4: `done` is high for one cycle, namely the cycle after a_0 is accepted, which is also the last `q_valid` cycle. In that cycle `rem` bit i equals the coefficient of x^i in A(x) mod B(x).
- R5: While no remainder is held, a cycle with `in_valid` low changes no stage and produces no `q_valid`.
- R6: While the remainder is held, `in_valid` and `in_bit` are ignored. With `shift_out` low, `rem` keeps its value until the next clear.
- R7: While the remainder is held, each cycle with `shift_out` high shifts the stages one place toward bit DEG_B−1, with a 0 entering bit 0 and no feedback. `rem_bit` always shows `rem[DEG_B-1]`, so the remainder leaves highest power first, and after DEG_B shifts `rem` is 0.
- R8: `shift_out` has no effect before the remainder is held.
- R9: Bit j of `b_coef` enables the feedback into stage j. With `b_coef` all zero the divisor is x^DEG_B, so the quotient is the top DEG_A−DEG_B+1 coefficients of A and the remainder is its low DEG_B coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear; starts a new division |
| b_coef | input | DEG_B | Divisor coefficients b_0..b_(DEG_B-1) |
| in_valid | input | 1 | Dividend coefficient present this cycle |
| in_bit | input | 1 | Dividend coefficient, highest power first |
| shift_out | input | 1 | Shift the held remainder out with feedback cut |
| q_valid | output | 1 | Quotient bit valid |
| q_bit | output | 1 | Quotient coefficient |
| done | output | 1 | One-cycle pulse after a_0 is absorbed |
| rem | output | DEG_B | Stage contents; the remainder once held |
| rem_bit | output | 1 | Serial remainder, top stage |

## Verification
The bench builds the block with the default DEG_A=9 and DEG_B=5. With those values, ten-bit dividends and all 32 divisor tap patterns fit in a short run. Random cases are mixed with the extreme tap words, all zero and all ones. The five-quotient-bit window and the five-bit remainder shift are then short enough to check one bit at a time. Random stalls, stray `shift_out` during division and aborted divisions followed by a clear exercise the timing paths around the state changes.

// File: rtl/gf2div_pkg.sv
package gf2div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_DIVIDE = 2'd2,
        ST_HOLD   = 2'd3
    } div_state_t;
endpackage

// File: rtl/gf2div_stage.sv
module gf2div_stage (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic fb_en,
    input  logic d_in,
    input  logic q_fb,
    input  logic tap,
    output logic r
);
    always_ff @(posedge clk) begin
        if (clr) begin
            r <= 1'b0;
        end else if (en) begin
            r <= d_in ^ (fb_en & q_fb & tap);
        end
    end
endmodule

// File: rtl/gf2div_ctrl.sv
module gf2div_ctrl
    import gf2div_pkg::*;
#(
    parameter int DEG_A = 9,
    parameter int DEG_B = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic in_valid,
    input  logic shift_out,
    input  logic msb,
    output logic step,
    output logic fb_en,
    output logic shift_en,
    output logic holding,
    output logic q_valid,
    output logic q_bit,
    output logic done
);
    localparam int CW = $clog2(DEG_A + 2);
    localparam logic [CW-1:0] LAST_IDX = CW'(DEG_A);
    localparam logic [CW-1:0] FILL_LEN = CW'(DEG_B);

    div_state_t state, nxt;
    logic [CW-1:0] cnt;
    logic          is_last;
    logic          will_fill;

    assign is_last   = (cnt == LAST_IDX);
    assign will_fill = ((cnt + 1'b1) >= FILL_LEN);

    // state register
    always_ff @(posedge clk) begin
        if (clr) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // accepted-coefficient counter
    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_FILL, ST_DIVIDE: begin
                if (in_valid) begin
                    if (is_last)        nxt = ST_HOLD;
                    else if (will_fill) nxt = ST_DIVIDE;
                    else                nxt = ST_FILL;
                end
            end
            ST_HOLD: nxt = ST_HOLD;
            default: nxt = ST_IDLE;
        endcase
    end

    // decoded controls
    always_comb begin
        holding  = (state == ST_HOLD);
        step     = in_valid && !holding;
        fb_en    = !holding;
        shift_en = holding && shift_out;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (clr) begin
            q_valid <= 1'b0;
            q_bit   <= 1'b0;
            done    <= 1'b0;
        end else begin
            q_valid <= step && (cnt >= FILL_LEN);
            q_bit   <= msb;
            done    <= step && is_last;
        end
    end
endmodule

// File: rtl/gf2div_serial.sv
module gf2div_serial #(
    parameter int DEG_A = 9,
    parameter int DEG_B = 5
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [DEG_B-1:0] b_coef,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             shift_out,
    output logic             q_valid,
    output logic             q_bit,
    output logic             done,
    output logic [DEG_B-1:0] rem,
    output logic             rem_bit
);
    logic [DEG_B-1:0] r;
    logic step, fb_en, shift_en, holding, stage_en, head;

    gf2div_ctrl #(.DEG_A(DEG_A), .DEG_B(DEG_B)) ctrl_i (
        .clk(clk), .clr(clr), .in_valid(in_valid), .shift_out(shift_out),
        .msb(r[DEG_B-1]), .step(step), .fb_en(fb_en), .shift_en(shift_en),
        .holding(holding), .q_valid(q_valid), .q_bit(q_bit), .done(done)
    );

    assign stage_en = step | shift_en;
    assign head     = in_bit & fb_en;

    for (genvar j = 0; j < DEG_B; j++) begin : g_stage
        logic d_in;
        if (j == 0) begin : g_head
            assign d_in = head;
        end else begin : g_body
            assign d_in = r[j-1];
        end
        gf2div_stage stage_i (
            .clk(clk), .clr(clr), .en(stage_en), .fb_en(fb_en),
            .d_in(d_in), .q_fb(r[DEG_B-1]), .tap(b_coef[j]), .r(r[j])
        );
    end

    assign rem     = r;
    assign rem_bit = r[DEG_B-1];
endmodule

// File: rtl/gf2div_checker.sv
module gf2div_checker #(
    parameter int DEG_A = 9,
    parameter int DEG_B = 5
) (
    input logic             clk,
    input logic             clr,
    input logic             in_valid,
    input logic             shift_out,
    input logic             holding,
    input logic             q_valid,
    input logic             done,
    input logic [DEG_B-1:0] rem
);
    localparam int NQ = DEG_A - DEG_B + 1;
    localparam int QW = $clog2(NQ + 2);

    logic [QW-1:0] qcnt;
    always_ff @(posedge clk) begin
        if (clr)          qcnt <= '0;
        else if (q_valid) qcnt <= qcnt + 1'b1;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk)
        clr |=> (rem == '0 && !q_valid && !done)); // R1

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (clr)
        (q_valid && !done) |-> (qcnt < QW'(NQ - 1))); // R2

    AST_QUOT_COUNT: assert property (@(posedge clk) disable iff (clr)
        done |-> (q_valid && qcnt == QW'(NQ - 1))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (clr)
        done |=> !done); // R4

    AST_STALL_STILL: assert property (@(posedge clk) disable iff (clr)
        (!holding && !in_valid) |=> ($stable(rem) && !q_valid)); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clr)
        (holding && !shift_out) |=> $stable(rem)); // R6

    AST_SHIFT_PLAIN: assert property (@(posedge clk) disable iff (clr)
        (holding && shift_out) |=> (rem == ($past(rem) << 1))); // R7
endmodule

bind gf2div_serial gf2div_checker #(.DEG_A(DEG_A), .DEG_B(DEG_B)) chk_i (
    .clk(clk), .clr(clr), .in_valid(in_valid), .shift_out(shift_out),
    .holding(holding), .q_valid(q_valid), .done(done), .rem(rem)
);

// File: tb/gf2div_serial_tb_top.sv
module gf2div_serial_tb_top;
    localparam int N = 9;
    localparam int M = 5;
    localparam int NQ = N - M + 1;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic [M-1:0] b_coef = '0;
    logic         in_valid = 1'b0;
    logic         in_bit = 1'b0;
    logic         shift_out = 1'b0;
    logic         q_valid, q_bit, done, rem_bit;
    logic [M-1:0] rem;

    int checks = 0;
    int fails = 0;
    int qseen = 0;
    logic exp_q[$];
    logic exp_e;

    always #4 clk = ~clk; // 125 MHz

    gf2div_serial #(.DEG_A(N), .DEG_B(M)) dut_i (
        .clk(clk), .clr(clr), .b_coef(b_coef), .in_valid(in_valid),
        .in_bit(in_bit), .shift_out(shift_out), .q_valid(q_valid),
        .q_bit(q_bit), .done(done), .rem(rem), .rem_bit(rem_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    function automatic void gf2_div(input logic [N:0] a, input logic [M-1:0] b,
                                    output logic [N-M:0] q, output logic [M-1:0] r);
        logic [N:0] w;
        logic [N:0] dv;
        w  = a;
        dv = {{(N-M){1'b0}}, 1'b1, b};
        q  = '0;
        for (int i = N; i >= M; i--) begin
            if (w[i]) begin
                w ^= dv << (i - M);
                q[i-M] = 1'b1;
            end
        end
        r = w[M-1:0];
    endfunction

    // monitor: scoreboard for the quotient stream
    always @(negedge clk) begin
        if (!clr && q_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected q_valid", int'(q_bit), 0);
            end else begin
                exp_e = exp_q.pop_front();
                chk(q_bit == exp_e, "R3 quotient bit", int'(q_bit), int'(exp_e));
            end
            qseen++;
        end
    end

    // driver
    task automatic run_div(input logic [N:0] a, input logic [M-1:0] b, input bit stall,
                           input bit noise, input int abort_at, input string rtag);
        logic [N-M:0] q;
        logic [M-1:0] r;
        logic [M-1:0] snap;
        int accepted;
        b_coef = b; in_valid = 1'b0; shift_out = 1'b0; clr = 1'b1;
        tick();
        exp_q.delete();
        qseen = 0;
        chk(rem == '0 && !q_valid && !done, "R1 clear", int'(rem), 0);
        clr = 1'b0;
        gf2_div(a, b, q, r);
        for (int i = N - M; i >= 0; i--) exp_q.push_back(q[i]);
        accepted = 0;
        for (int i = N; i >= 0; i--) begin
            if (accepted == abort_at) return;
            if (stall && $urandom_range(0, 2) == 0) begin
                in_valid = 1'b0;
                shift_out = noise ? 1'($urandom_range(0, 1)) : 1'b0;
                snap = rem;
                tick();
                chk(rem == snap && !q_valid, "R5 stall", int'(rem), int'(snap));
            end
            in_valid = 1'b1;
            in_bit = a[i];
            shift_out = noise ? 1'($urandom_range(0, 1)) : 1'b0;
            tick();
            accepted++;
            in_valid = 1'b0;
            if (accepted <= M) chk(!q_valid, "R2 no quotient while filling", int'(q_valid), 0);
        end
        shift_out = 1'b0;
        chk(done, "R4 done pulse", int'(done), 1);
        chk(rem == r, rtag, int'(rem), int'(r));
        chk(exp_q.size() == 0 && qseen == NQ, "R3 quotient count", qseen, NQ);
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1;
            in_bit = 1'($urandom_range(0, 1));
            tick();
            chk(rem == r && !q_valid && !done, "R6 input ignored in hold", int'(rem), int'(r));
        end
        in_valid = 1'b0;
        shift_out = 1'b1;
        for (int k = 0; k < M; k++) begin
            chk(rem_bit == r[M-1-k], "R7 serial remainder", int'(rem_bit), int'(r[M-1-k]));
            tick();
        end
        chk(rem == '0, "R7 drained", int'(rem), 0);
        shift_out = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        run_div(10'b10_0000_0000, 5'b00000, 0, 0, -1, "R9 remainder, zero taps");
        run_div(10'b11_0101_1011, 5'b00000, 0, 0, -1, "R9 remainder, zero taps");
        run_div(10'b11_1111_1111, 5'b11111, 0, 0, -1, "R9 remainder, all taps");
        run_div(10'b10_0110_0001, 5'b00101, 0, 0, -1, "R4 remainder");
        run_div(10'b01_1100_1010, 5'b10011, 1, 0, 7, "R4 remainder");
        run_div(10'b00_0000_0000, 5'b01101, 0, 0, -1, "R4 remainder, zero dividend");
        for (int t = 0; t < 40; t++) begin
            if (t % 2 == 0)
                run_div(10'($urandom), 5'($urandom), 1, 1, -1, "R8 remainder with stray shift_out");
            else
                run_div(10'($urandom), 5'($urandom), 1, 0, (t % 5 == 1) ? 4 : -1, "R4 remainder");
        end
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        summary();
        $finish;
    end
endmodule